// File: doc/BRIEF.md
# Scalar-Vector Execute Unit

This block is the execute stage of a small single-issue integer pipeline whose instruction set also carries short vector instructions. Each cycle it may accept one decoded operation together with three scalar operands, two vector operands, the program counter of the instruction and the active vector length. One clock later it presents a registered scalar result, a registered vector result and the updated four-bit condition-code register.

The scalar path covers wrapping arithmetic with overflow and underflow detection, bitwise logic, shifts, signed compare, truncating division, and the target and address arithmetic for jumps, conditional branches, loads, stores, push and pop. The vector path runs one lane per element, all lanes in the same cycle, and writes only the elements below the active length. A zero active length clears the vector destination. A branch that is not taken returns an all-ones sentinel in place of a target, so the fetch logic needs no separate taken bit.

Top module: `sve_exec_unit`

## Requirements
- R1: Reset clears the valid output, the scalar result, the vector result and the flags. An operation accepted with `in_valid` high appears on the outputs with `out_valid` high on the next rising edge. Flag bits are bit 0 overflow (OF), bit 1 underflow (UF), bit 2 greater-than (GT) and bit 3 equal (EQ). Opcodes are the values of `sve_op_e` in `sve_pkg`.
- R2: Scalar add, subtract and multiply (and add/subtract immediate, with the immediate on `in_s3`) return the low W bits of the result. OF is set when the exact signed result is above the largest W-bit value, UF when it is below the smallest. Both are cleared otherwise.
- R3: AND, OR, XOR, NOT and their immediate forms clear OF and UF. NOT inverts operand one.
- R4: Right shifts are arithmetic and left shifts are logical. The shift amount is the low log2(W) bits of operand two (or of the immediate), and shifts leave the flags unchanged.
- R5: Quotient and remainder truncate toward zero. A zero divisor returns zero, and neither operation, scalar or vector, changes any flag.
- R6: Compare sets GT when operand one is greater than operand two as signed values, and sets EQ when the two are equal. Each flag is cleared otherwise.
- R7: A branch on EQ, GT, UF or OF returns PC plus operand two when its flag is set and all ones when it is clear.
- R8: Register-relative jump returns PC plus operand two. Plain jump and jump-and-link return operand one plus operand two. Load, store, push, pop, vector load and vector store return operand one plus the immediate.
- R9: Vector add, subtract, multiply and divide work element-wise on the elements below the active length. The other elements carry the first vector operand through. A length above the lane count is treated as the lane count.
- R10: Vector add, subtract and multiply set OF and UF from the highest active element only. A zero length leaves all flags unchanged.
- R11: Any vector operation with a zero active length returns an all-zero vector result.
- R12: Vector compare-equal sets EQ when every active element of both operands matches and clears EQ otherwise. A zero length sets EQ.
- R13: A cycle with `in_valid` low drives `out_valid` low and leaves the flags and both results unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An operation is presented this cycle |
| in_op | input | 6 | Operation code (`sve_op_e`) |
| in_s1 | input | W | Scalar operand one / base address |
| in_s2 | input | W | Scalar operand two / branch and jump offset |
| in_s3 | input | W | Immediate |
| in_pc | input | W | Program counter of the operation |
| in_va | input | W*LANES | First vector operand, element i at bits [i*W +: W] |
| in_vb | input | W*LANES | Second vector operand, same layout |
| in_vlen | input | clog2(LANES)+2 | Requested active vector length |
| out_valid | output | 1 | Registered result is new this cycle |
| out_scalar | output | W | Scalar result, target or address |
| out_vector | output | W*LANES | Vector result |
| out_flags | output | 4 | Condition-code register {EQ, GT, UF, OF} |

## Verification
The assertions assume that `in_op` always holds a defined `sve_op_e` value and that the inputs settle well away from the rising edge. They also assume that reset is applied before the first operation, because the flag register has no other initial value. The stimulus drives every input on the falling edge from a fixed table and from directed cases that use only named opcodes. The active lengths it uses span zero, partial lengths, the full lane count and a value above it. It also leaves idle cycles with unrelated operand values on the bus, so the hold behaviour is tested without breaking these assumptions.

// File: rtl/sve_pkg.sv
package sve_pkg;

    localparam int OP_W   = 6;
    localparam int FLAG_W = 4;

    // Bit positions inside the condition-code register
    localparam int FLG_OF = 0;
    localparam int FLG_UF = 1;
    localparam int FLG_GT = 2;
    localparam int FLG_EQ = 3;

    typedef enum logic [OP_W-1:0] {
        OP_NOP, OP_ADD, OP_SUB, OP_MUL, OP_QUOT, OP_REM, OP_SHR, OP_SHL,
        OP_AND, OP_OR, OP_XOR, OP_NOT, OP_CMP, OP_ADDI, OP_SUBI, OP_SHRI,
        OP_SHLI, OP_ANDI, OP_ORI, OP_XORI, OP_LOAD, OP_STORE, OP_PUSH, OP_POP,
        OP_JMP, OP_JAL, OP_JRL, OP_BEQ, OP_BGT, OP_BUF, OP_BOF, OP_VADD,
        OP_VSUB, OP_VMUL, OP_VDIV, OP_VCMPEQ, OP_VLOAD, OP_VSTORE, OP_RET
    } sve_op_e;

    // Per-flag write enable and value produced by one operation
    typedef struct packed {
        logic of_we;
        logic of_v;
        logic uf_we;
        logic uf_v;
        logic gt_we;
        logic gt_v;
        logic eq_we;
        logic eq_v;
    } flag_upd_t;

    function automatic logic is_logic_op(sve_op_e op);
        return op inside {OP_AND, OP_OR, OP_XOR, OP_NOT, OP_ANDI, OP_ORI, OP_XORI};
    endfunction

    function automatic logic is_vec_op(sve_op_e op);
        return op inside {OP_VADD, OP_VSUB, OP_VMUL, OP_VDIV, OP_VCMPEQ,
                          OP_VLOAD, OP_VSTORE};
    endfunction

    function automatic logic is_vec_guarded(sve_op_e op);
        return op inside {OP_VADD, OP_VSUB, OP_VMUL};
    endfunction

    // Operations whose second ALU operand is the immediate
    function automatic logic uses_imm(sve_op_e op);
        return op inside {OP_ADDI, OP_SUBI, OP_SHRI, OP_SHLI, OP_ANDI, OP_ORI,
                          OP_XORI, OP_LOAD, OP_STORE, OP_PUSH, OP_POP,
                          OP_VLOAD, OP_VSTORE};
    endfunction

    function automatic logic [FLAG_W-1:0] apply_upd(logic [FLAG_W-1:0] f, flag_upd_t u);
        logic [FLAG_W-1:0] r;
        r = f;
        if (u.of_we) r[FLG_OF] = u.of_v;
        if (u.uf_we) r[FLG_UF] = u.uf_v;
        if (u.gt_we) r[FLG_GT] = u.gt_v;
        if (u.eq_we) r[FLG_EQ] = u.eq_v;
        return r;
    endfunction

endpackage

// File: rtl/sve_arith_guard.sv
module sve_arith_guard #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum,
    output logic [W-1:0] dif,
    output logic [W-1:0] prod,
    output logic         add_of,
    output logic         add_uf,
    output logic         sub_of,
    output logic         sub_uf,
    output logic         mul_of,
    output logic         mul_uf
);
    localparam int PW = 2 * W;

    logic signed [PW-1:0] full;

    always_comb begin
        sum  = a + b;
        dif  = a - b;
        full = $signed(a) * $signed(b);
        prod = full[W-1:0];
        // same-sign addends whose sum flips sign
        add_of = !a[W-1] && !b[W-1] &&  sum[W-1];
        add_uf =  a[W-1] &&  b[W-1] && !sum[W-1];
        // opposite-sign operands whose difference leaves the minuend's sign
        sub_of = !a[W-1] &&  b[W-1] &&  dif[W-1];
        sub_uf =  a[W-1] && !b[W-1] && !dif[W-1];
        // product fits only if the top W+1 bits are a pure sign extension
        mul_of = !full[PW-1] && (full[PW-1:W-1] != '0);
        mul_uf =  full[PW-1] && (full[PW-1:W-1] != '1);
    end

endmodule

// File: rtl/sve_safe_div.sv
module sve_safe_div #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         want_rem,
    output logic [W-1:0] res
);
    localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

    logic signed [W-1:0] sa;
    logic signed [W-1:0] sb;
    logic signed [W-1:0] q;
    logic signed [W-1:0] r;

    always_comb begin
        sa = a;
        sb = b;
        if (b == '0) begin
            q = '0;
            r = '0;
        end else if (a == MOST_NEG && b == '1) begin
            // the one quotient that does not fit wraps to the dividend
            q = sa;
            r = '0;
        end else begin
            q = sa / sb;
            r = sa % sb;
        end
        res = want_rem ? r : q;
    end

endmodule

// File: rtl/sve_scalar_alu.sv
module sve_scalar_alu
    import sve_pkg::*;
#(
    parameter int W = 32
) (
    input  sve_op_e           op,
    input  logic [W-1:0]      a,
    input  logic [W-1:0]      b,
    input  logic [W-1:0]      imm,
    input  logic [W-1:0]      pc,
    input  logic [FLAG_W-1:0] flags,
    output logic [W-1:0]      res,
    output flag_upd_t         upd
);
    localparam int SH_W = $clog2(W);

    logic [W-1:0]    opb;
    logic [W-1:0]    sum, dif, prod, div_res, pc_tgt;
    logic            add_of, add_uf, sub_of, sub_uf, mul_of, mul_uf;
    logic [SH_W-1:0] sh;

    assign opb    = uses_imm(op) ? imm : b;
    assign sh     = opb[SH_W-1:0];
    assign pc_tgt = pc + b;

    sve_arith_guard #(.W(W)) guard_i (
        .a(a), .b(opb), .sum(sum), .dif(dif), .prod(prod),
        .add_of(add_of), .add_uf(add_uf), .sub_of(sub_of), .sub_uf(sub_uf),
        .mul_of(mul_of), .mul_uf(mul_uf)
    );

    sve_safe_div #(.W(W)) div_i (
        .a(a), .b(opb), .want_rem(op == OP_REM), .res(div_res)
    );

    always_comb begin
        res = a;
        upd = '0;
        if (is_logic_op(op)) begin
            upd.of_we = 1'b1;
            upd.uf_we = 1'b1;
        end
        case (op)
            OP_ADD, OP_ADDI: begin
                res = sum;
                upd.of_we = 1'b1; upd.of_v = add_of;
                upd.uf_we = 1'b1; upd.uf_v = add_uf;
            end
            OP_SUB, OP_SUBI: begin
                res = dif;
                upd.of_we = 1'b1; upd.of_v = sub_of;
                upd.uf_we = 1'b1; upd.uf_v = sub_uf;
            end
            OP_MUL: begin
                res = prod;
                upd.of_we = 1'b1; upd.of_v = mul_of;
                upd.uf_we = 1'b1; upd.uf_v = mul_uf;
            end
            OP_QUOT, OP_REM:  res = div_res;
            OP_SHR, OP_SHRI:  res = W'($signed(a) >>> sh);
            OP_SHL, OP_SHLI:  res = a << sh;
            OP_AND, OP_ANDI:  res = a & opb;
            OP_OR,  OP_ORI:   res = a | opb;
            OP_XOR, OP_XORI:  res = a ^ opb;
            OP_NOT:           res = ~a;
            OP_CMP: begin
                upd.gt_we = 1'b1; upd.gt_v = $signed(a) > $signed(b);
                upd.eq_we = 1'b1; upd.eq_v = (a == b);
            end
            OP_LOAD, OP_STORE, OP_PUSH, OP_POP, OP_VLOAD, OP_VSTORE,
            OP_JMP, OP_JAL:   res = sum;
            OP_JRL:           res = pc_tgt;
            OP_BEQ:           res = flags[FLG_EQ] ? pc_tgt : '1;
            OP_BGT:           res = flags[FLG_GT] ? pc_tgt : '1;
            OP_BUF:           res = flags[FLG_UF] ? pc_tgt : '1;
            OP_BOF:           res = flags[FLG_OF] ? pc_tgt : '1;
            default:          res = a;
        endcase
    end

endmodule

// File: rtl/sve_vector_lane.sv
module sve_vector_lane
    import sve_pkg::*;
#(
    parameter int W = 32
) (
    input  sve_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res,
    output logic         of,
    output logic         uf,
    output logic         match
);
    logic [W-1:0] sum, dif, prod, quot;
    logic         add_of, add_uf, sub_of, sub_uf, mul_of, mul_uf;

    sve_arith_guard #(.W(W)) guard_i (
        .a(a), .b(b), .sum(sum), .dif(dif), .prod(prod),
        .add_of(add_of), .add_uf(add_uf), .sub_of(sub_of), .sub_uf(sub_uf),
        .mul_of(mul_of), .mul_uf(mul_uf)
    );

    sve_safe_div #(.W(W)) div_i (
        .a(a), .b(b), .want_rem(1'b0), .res(quot)
    );

    assign match = (a == b);

    always_comb begin
        res = a;
        of  = 1'b0;
        uf  = 1'b0;
        case (op)
            OP_VADD: begin res = sum;  of = add_of; uf = add_uf; end
            OP_VSUB: begin res = dif;  of = sub_of; uf = sub_uf; end
            OP_VMUL: begin res = prod; of = mul_of; uf = mul_uf; end
            OP_VDIV:       res = quot;
            default:       res = a;
        endcase
    end

endmodule

// File: rtl/sve_exec_unit.sv
module sve_exec_unit
    import sve_pkg::*;
#(
    parameter int W     = 32,
    parameter int LANES = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [5:0]             in_op,
    input  logic [W-1:0]           in_s1,
    input  logic [W-1:0]           in_s2,
    input  logic [W-1:0]           in_s3,
    input  logic [W-1:0]           in_pc,
    input  logic [W*LANES-1:0]     in_va,
    input  logic [W*LANES-1:0]     in_vb,
    input  logic [$clog2(LANES)+1:0] in_vlen,
    output logic                   out_valid,
    output logic [W-1:0]           out_scalar,
    output logic [W*LANES-1:0]     out_vector,
    output logic [3:0]             out_flags
);
    localparam int VEC_W = W * LANES;
    localparam int VL_W  = $clog2(LANES) + 2;
    localparam logic [VL_W-1:0] VL_MAX = VL_W'(LANES);

    typedef struct packed {
        logic              valid;
        logic [W-1:0]      scalar;
        logic [VEC_W-1:0]  vector;
        logic [FLAG_W-1:0] flags;
    } exec_state_t;

    exec_state_t st_d, st_q;

    sve_op_e          op;
    logic [VL_W-1:0]  vlen_eff;
    logic [W-1:0]     alu_res;
    flag_upd_t        alu_upd;
    logic [LANES-1:0] active, lane_of, lane_uf, lane_match;
    logic [W-1:0]     lane_res [LANES];

    assign op       = sve_op_e'(in_op);
    assign vlen_eff = (in_vlen > VL_MAX) ? VL_MAX : in_vlen;

    sve_scalar_alu #(.W(W)) alu_i (
        .op(op), .a(in_s1), .b(in_s2), .imm(in_s3), .pc(in_pc),
        .flags(st_q.flags), .res(alu_res), .upd(alu_upd)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign active[g] = (VL_W'(g) < vlen_eff);

        sve_vector_lane #(.W(W)) lane_i (
            .op(op),
            .a(in_va[g*W +: W]),
            .b(in_vb[g*W +: W]),
            .res(lane_res[g]),
            .of(lane_of[g]),
            .uf(lane_uf[g]),
            .match(lane_match[g])
        );
    end

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.scalar = alu_res;
            st_d.flags  = apply_upd(st_q.flags, alu_upd);
            if (is_vec_op(op)) begin
                for (int i = 0; i < LANES; i++) begin
                    st_d.vector[i*W +: W] = active[i] ? lane_res[i] : in_va[i*W +: W];
                end
                if (is_vec_guarded(op) && vlen_eff != '0) begin
                    for (int i = 0; i < LANES; i++) begin
                        if (VL_W'(i) == vlen_eff - 1'b1) begin
                            st_d.flags[FLG_OF] = lane_of[i];
                            st_d.flags[FLG_UF] = lane_uf[i];
                        end
                    end
                end
                if (op == OP_VCMPEQ) begin
                    st_d.flags[FLG_EQ] = &(lane_match | ~active);
                end
                if (vlen_eff == '0) begin
                    st_d.vector = '0;
                end
            end else begin
                st_d.vector = in_va;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid  = st_q.valid;
    assign out_scalar = st_q.scalar;
    assign out_vector = st_q.vector;
    assign out_flags  = st_q.flags;

endmodule

// File: rtl/sve_exec_checker.sv
module sve_exec_checker
    import sve_pkg::*;
#(
    parameter int W     = 32,
    parameter int LANES = 4
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     in_valid,
    input logic [5:0]               in_op,
    input logic [$clog2(LANES)+1:0] in_vlen,
    input logic                     out_valid,
    input logic [W-1:0]             out_scalar,
    input logic [W*LANES-1:0]       out_vector,
    input logic [3:0]               out_flags
);
    logic op_logic, op_vec, op_beq, op_cmp;

    assign op_logic = is_logic_op(sve_op_e'(in_op));
    assign op_vec   = is_vec_op(sve_op_e'(in_op));
    assign op_beq   = (in_op == OP_BEQ);
    assign op_cmp   = (in_op == OP_CMP);

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R1

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && $stable(out_flags) && $stable(out_scalar)); // R13

    AST_LOGIC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && op_logic |=> out_flags[FLG_OF] == 1'b0 && out_flags[FLG_UF] == 1'b0); // R3

    AST_BRANCH_SENTINEL: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && op_beq && !out_flags[FLG_EQ] |=> out_scalar == '1); // R7

    AST_ZERO_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && op_vec && in_vlen == '0 |=> out_vector == '0); // R11

    AST_CMP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && op_cmp |=> !(out_flags[FLG_GT] && out_flags[FLG_EQ])); // R6

endmodule

bind sve_exec_unit sve_exec_checker #(.W(W), .LANES(LANES)) chk_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_vlen(in_vlen), .out_valid(out_valid), .out_scalar(out_scalar),
    .out_vector(out_vector), .out_flags(out_flags)
);

// File: tb/sve_exec_unit_tb_top.sv
module sve_exec_unit_tb_top;
    import sve_pkg::*;

    localparam int W     = 32;
    localparam int LANES = 4;
    localparam int VEC_W = W * LANES;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic [5:0]       in_op = '0;
    logic [W-1:0]     in_s1 = '0, in_s2 = '0, in_s3 = '0, in_pc = '0;
    logic [VEC_W-1:0] in_va = '0, in_vb = '0;
    logic [3:0]       in_vlen = '0;
    logic             out_valid;
    logic [W-1:0]     out_scalar;
    logic [VEC_W-1:0] out_vector;
    logic [3:0]       out_flags;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    sve_exec_unit #(.W(W), .LANES(LANES)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_s1(in_s1), .in_s2(in_s2), .in_s3(in_s3), .in_pc(in_pc),
        .in_va(in_va), .in_vb(in_vb), .in_vlen(in_vlen),
        .out_valid(out_valid), .out_scalar(out_scalar),
        .out_vector(out_vector), .out_flags(out_flags)
    );

    typedef struct packed {
        logic [5:0]  op;
        logic [31:0] a, b, c, pc, exp;
        logic [3:0]  fm, fv;
        logic [3:0]  rq;
    } tv_t;

    localparam int NV = 37;
    localparam tv_t TV [NV] = '{
        '{OP_ADD,   32'h5,        32'h7,        32'h0,        32'h0,   32'hc,        4'h3, 4'h0, 4'd2},  // R2
        '{OP_ADD,   32'h7fffffff, 32'h1,        32'h0,        32'h0,   32'h80000000, 4'h3, 4'h1, 4'd2},  // R2
        '{OP_BOF,   32'h0,        32'h50,       32'h0,        32'h0,   32'h50,       4'h0, 4'h0, 4'd7},  // R7
        '{OP_ANDI,  32'hf0f0,     32'h0,        32'hff00,     32'h0,   32'hf000,     4'h3, 4'h0, 4'd3},  // R3
        '{OP_BOF,   32'h0,        32'h50,       32'h0,        32'h0,   32'hffffffff, 4'h0, 4'h0, 4'd7},  // R7
        '{OP_ADD,   32'h80000000, 32'hffffffff, 32'h0,        32'h0,   32'h7fffffff, 4'h3, 4'h2, 4'd2},  // R2
        '{OP_BUF,   32'h0,        32'h4,        32'h0,        32'h10,  32'h14,       4'h0, 4'h0, 4'd7},  // R7
        '{OP_SUB,   32'h80000000, 32'h1,        32'h0,        32'h0,   32'h7fffffff, 4'h3, 4'h2, 4'd2},  // R2
        '{OP_SUB,   32'h7fffffff, 32'hffffffff, 32'h0,        32'h0,   32'h80000000, 4'h3, 4'h1, 4'd2},  // R2
        '{OP_MUL,   32'h10000,    32'h10000,    32'h0,        32'h0,   32'h0,        4'h3, 4'h1, 4'd2},  // R2
        '{OP_MUL,   32'hfffffffd, 32'h4,        32'h0,        32'h0,   32'hfffffff4, 4'h3, 4'h0, 4'd2},  // R2
        '{OP_MUL,   32'h10000,    32'hffff0000, 32'h0,        32'h0,   32'h0,        4'h3, 4'h2, 4'd2},  // R2
        '{OP_OR,    32'hf00,      32'hf0,       32'h0,        32'h0,   32'hff0,      4'h3, 4'h0, 4'd3},  // R3
        '{OP_XORI,  32'hff,       32'h0,        32'hf,        32'h0,   32'hf0,       4'h3, 4'h0, 4'd3},  // R3
        '{OP_NOT,   32'h0,        32'h0,        32'h0,        32'h0,   32'hffffffff, 4'h3, 4'h0, 4'd3},  // R3
        '{OP_SHR,   32'h80000000, 32'h4,        32'h0,        32'h0,   32'hf8000000, 4'h0, 4'h0, 4'd4},  // R4
        '{OP_SHLI,  32'h1,        32'h0,        32'h5,        32'h0,   32'h20,       4'h0, 4'h0, 4'd4},  // R4
        '{OP_SHL,   32'h3,        32'h21,       32'h0,        32'h0,   32'h6,        4'h0, 4'h0, 4'd4},  // R4
        '{OP_QUOT,  32'hfffffff9, 32'h2,        32'h0,        32'h0,   32'hfffffffd, 4'h0, 4'h0, 4'd5},  // R5
        '{OP_REM,   32'hfffffff9, 32'h2,        32'h0,        32'h0,   32'hffffffff, 4'h0, 4'h0, 4'd5},  // R5
        '{OP_ADDI,  32'h7fffffff, 32'h0,        32'h1,        32'h0,   32'h80000000, 4'h3, 4'h1, 4'd2},  // R2
        '{OP_QUOT,  32'h9,        32'h0,        32'h0,        32'h0,   32'h0,        4'h3, 4'h1, 4'd5},  // R5
        '{OP_REM,   32'h9,        32'h0,        32'h0,        32'h0,   32'h0,        4'h3, 4'h1, 4'd5},  // R5
        '{OP_CMP,   32'h5,        32'h3,        32'h0,        32'h0,   32'h5,        4'hc, 4'h4, 4'd6},  // R6
        '{OP_BGT,   32'h0,        32'h20,       32'h0,        32'h100, 32'h120,      4'h0, 4'h0, 4'd7},  // R7
        '{OP_BEQ,   32'h0,        32'h20,       32'h0,        32'h100, 32'hffffffff, 4'h0, 4'h0, 4'd7},  // R7
        '{OP_CMP,   32'hfffffffe, 32'hfffffffe, 32'h0,        32'h0,   32'hfffffffe, 4'hc, 4'h8, 4'd6},  // R6
        '{OP_BEQ,   32'h0,        32'hfffffff8, 32'h0,        32'h40,  32'h38,       4'h0, 4'h0, 4'd7},  // R7
        '{OP_CMP,   32'hfffffffe, 32'h3,        32'h0,        32'h0,   32'hfffffffe, 4'hc, 4'h0, 4'd6},  // R6
        '{OP_JRL,   32'h0,        32'h4,        32'h0,        32'h10,  32'h14,       4'h0, 4'h0, 4'd8},  // R8
        '{OP_JMP,   32'h200,      32'h8,        32'h0,        32'h0,   32'h208,      4'h0, 4'h0, 4'd8},  // R8
        '{OP_JAL,   32'h300,      32'hfffffffc, 32'h0,        32'h0,   32'h2fc,      4'h0, 4'h0, 4'd8},  // R8
        '{OP_LOAD,  32'h1000,     32'h0,        32'hfffffffc, 32'h0,   32'hffc,      4'h0, 4'h0, 4'd8},  // R8
        '{OP_STORE, 32'h20,       32'h0,        32'h4,        32'h0,   32'h24,       4'h0, 4'h0, 4'd8},  // R8
        '{OP_PUSH,  32'h7,        32'h0,        32'hffffffff, 32'h0,   32'h6,        4'h0, 4'h0, 4'd8},  // R8
        '{OP_POP,   32'h7,        32'h0,        32'h1,        32'h0,   32'h8,        4'h0, 4'h0, 4'd8},  // R8
        '{OP_VLOAD, 32'h400,      32'h0,        32'h10,       32'h0,   32'h410,      4'h0, 4'h0, 4'd8}   // R8
    };

    function automatic logic [VEC_W-1:0] pack4(logic [31:0] e0, e1, e2, e3);
        return {e3, e2, e1, e0};
    endfunction

    task automatic chk(input string req, input logic [VEC_W-1:0] act, input logic [VEC_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive one operation at a falling edge; return at the next falling edge
    task automatic issue(input sve_op_e op, input logic [31:0] a, b, c, pc,
                         input logic [VEC_W-1:0] va, vb, input logic [3:0] vlen);
        in_valid = 1'b1; in_op = op;
        in_s1 = a; in_s2 = b; in_s3 = c; in_pc = pc;
        in_va = va; in_vb = vb; in_vlen = vlen;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [VEC_W-1:0] z;
        z = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 reset valid", VEC_W'(out_valid), '0);
        chk("R1 reset flags", VEC_W'(out_flags), '0);
        chk("R1 reset scalar", VEC_W'(out_scalar), '0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            issue(sve_op_e'(TV[i].op), TV[i].a, TV[i].b, TV[i].c, TV[i].pc, z, z, 4'd1);
            chk($sformatf("R%0d vec %0d result", TV[i].rq, i), VEC_W'(out_scalar), VEC_W'(TV[i].exp));
            chk($sformatf("R%0d vec %0d flags", TV[i].rq, i),
                VEC_W'(out_flags & TV[i].fm), VEC_W'(TV[i].fv));
        end
        chk("R1 valid after issue", VEC_W'(out_valid), 1);

        // R9: partial length, upper lane passes through
        issue(OP_VADD, 0, 0, 0, 0, pack4(10, 20, 30, 40), pack4(1, 2, 3, 4), 4'd3);
        chk("R9 vadd len3", out_vector, pack4(11, 22, 33, 40));
        chk("R10 vadd len3 flags", VEC_W'(out_flags[1:0]), 0);
        // R10: overflow in lane 0 only, highest active lane is lane 1
        issue(OP_VADD, 0, 0, 0, 0, pack4(32'h7fffffff, 5, 32'h7fffffff, 0), pack4(1, 1, 1, 0), 4'd2);
        chk("R9 vadd len2", out_vector, pack4(32'h80000000, 6, 32'h7fffffff, 0));
        chk("R10 vadd highest lane", VEC_W'(out_flags[1:0]), 0);
        issue(OP_VSUB, 0, 0, 0, 0, pack4(0, 32'h80000000, 3, 3), pack4(0, 1, 1, 1), 4'd2);
        chk("R9 vsub len2", out_vector, pack4(0, 32'h7fffffff, 3, 3));
        chk("R10 vsub underflow", VEC_W'(out_flags[1:0]), 2);
        // R11 / R10: zero length clears vector and keeps flags
        issue(OP_VMUL, 0, 0, 0, 0, pack4(2, 3, 4, 5), pack4(3, 3, 3, 3), 4'd0);
        chk("R11 zero length", out_vector, '0);
        chk("R10 zero length flags held", VEC_W'(out_flags[1:0]), 2);
        // R9: length above lane count is clamped
        issue(OP_VMUL, 0, 0, 0, 0, pack4(2, 3, 4, 5), pack4(3, 3, 3, 3), 4'd7);
        chk("R9 clamp", out_vector, pack4(6, 9, 12, 15));
        chk("R10 vmul flags", VEC_W'(out_flags[1:0]), 0);
        // R5: vector divide incl. zero divisor
        issue(OP_VDIV, 0, 0, 0, 0, pack4(20, 32'hfffffff7, 7, 8), pack4(4, 2, 0, 8), 4'd4);
        chk("R5 vdiv", out_vector, pack4(5, 32'hfffffffc, 0, 1));
        // R12: compare-equal
        issue(OP_VCMPEQ, 0, 0, 0, 0, pack4(1, 2, 3, 4), pack4(1, 2, 9, 9), 4'd2);
        chk("R12 cmpeq match", VEC_W'(out_flags[3]), 1);
        issue(OP_VCMPEQ, 0, 0, 0, 0, pack4(1, 2, 3, 4), pack4(1, 2, 9, 9), 4'd3);
        chk("R12 cmpeq mismatch", VEC_W'(out_flags[3]), 0);
        issue(OP_VCMPEQ, 0, 0, 0, 0, pack4(1, 2, 3, 4), pack4(5, 6, 7, 8), 4'd0);
        chk("R12 cmpeq zero length", VEC_W'(out_flags[3]), 1);
        chk("R11 cmpeq zero length vector", out_vector, '0);

        // R13: idle cycle holds outputs
        issue(OP_ADD, 32'h7fffffff, 1, 0, 0, z, z, 4'd1);
        in_op = OP_AND; in_s1 = 32'h1234; in_s2 = 32'h5;
        @(negedge clk);
        chk("R13 idle valid", VEC_W'(out_valid), 0);
        chk("R13 idle flags", VEC_W'(out_flags), VEC_W'(out_flags | 4'h1) & VEC_W'(4'hf));
        chk("R13 idle of kept", VEC_W'(out_flags[0]), 1);
        chk("R13 idle scalar", VEC_W'(out_scalar), 32'h80000000);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule